// File: doc/BRIEF.md
# Program/Erase Status Bit Generator

This block decides what the read path of a parallel flash shows while the array engine programs or erases. It follows each operation from the start pulse to the done or fail pulse and tells the read multiplexer whether to return array data or status. While status is shown it drives two polling bits: a completion bit (the bit position given by `POLL_BIT`, bit 7 by default) and a toggle bit (bit 6).

A one-bit configuration register selects between two polling styles. Its legal codes are 00 and 01, and it is written by a set-configuration request that an upstream decoder raises after the four-cycle command. In style 00 the completion bit shows the inverse of the programmed word's bit 7 during a program and 0 during an erase, and a successful operation returns to array reads by itself. In style 01 the completion bit is 0 while busy and 1 when finished, and the read path stays on status until an exit request arrives. In both styles a failed operation holds status until the exit request. The register is cleared only by power-on reset. The device reset pin returns the sequencer to read mode and leaves the register alone.

The sequencer has four states. READ shows array data. BUSY is entered from READ on `op_start`. BUSY goes to READ on `op_done` in style 00, to DONE_WAIT on `op_done` in style 01, and to FAIL_WAIT on `op_fail`, which wins over `op_done`. DONE_WAIT and FAIL_WAIT both go back to READ on `id_exit`.

Top module: `pestat_gen`

## Requirements
- R1: After power-on reset the style is 00, the state is READ, `show_status` is 0, and `dq7` and `dq6` are 0. A later power-on reset puts the style back to 00.
- R2: `cfg_wr` with `cfg_val` 2'b00 or 2'b01 sets the style to that value from the next cycle. `cfg_wr` with 2'b10 or 2'b11 is ignored and the style is unchanged.
- R3: Holding `dev_rst_n` low returns the state to READ and clears the toggle bit. The style register is not changed.
- R4: In style 00, while BUSY, `dq7` is the inverse of bit `POLL_BIT` of `op_data` captured at start for a program (`op_is_erase`=0), and 0 for an erase (`op_is_erase`=1).
- R5: `show_status` is 1 in every state except READ, and `dq7`/`dq6` are 0 in READ. In style 00, `op_done` without `op_fail` in BUSY gives array reads from the next cycle.
- R6: In style 01, `dq7` is 0 while BUSY. After `op_done`, `dq7` is 1 and status stays shown until `id_exit`.
- R7: `op_fail` in BUSY, in either style, holds status until `id_exit`. During the hold `dq7` keeps its BUSY value.
- R8: `dq6` is 0 when an operation starts. It inverts after each `rd_stb` cycle in BUSY and stays frozen in DONE_WAIT and FAIL_WAIT.
- R9: `id_exit` in READ or BUSY has no effect. `op_start` outside READ is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| dev_rst_n | input | 1 | Device reset pin, asynchronous, active low; leaves the style register alone |
| op_start | input | 1 | Operation start pulse from the array engine |
| op_is_erase | input | 1 | 1 for erase, 0 for program; sampled with `op_start` |
| op_data | input | DATA_W | Word being programmed; sampled with `op_start` |
| op_done | input | 1 | Operation finished successfully |
| op_fail | input | 1 | Operation failed |
| rd_stb | input | 1 | One-cycle read strobe |
| cfg_wr | input | 1 | Set-configuration request |
| cfg_val | input | 2 | Requested style code |
| id_exit | input | 1 | Exit request that returns to read mode |
| show_status | output | 1 | 1 selects status, 0 selects array data |
| dq7 | output | 1 | Completion polling bit |
| dq6 | output | 1 | Toggle bit |

## Verification
The bench uses the defaults `DATA_W`=16 and `POLL_BIT`=7, so the captured bit is bit 7 of a 16-bit word. Random words give both values of that bit in both styles. Random mixes of start, done, fail, exit, read strobe, device reset and configuration writes, including illegal codes, drive the sequencer through every state and through simultaneous done and fail. Directed sequences cover the power-on return to style 00 and the device reset that keeps style 01.

// File: rtl/pestat_pkg.sv
package pestat_pkg;
    typedef enum logic [1:0] {
        ST_READ      = 2'd0,
        ST_BUSY      = 2'd1,
        ST_DONE_WAIT = 2'd2,
        ST_FAIL_WAIT = 2'd3
    } state_t;

    localparam logic [1:0] CFG_AUTO = 2'b00;
    localparam logic [1:0] CFG_HOLD = 2'b01;
endpackage

// File: rtl/pestat_cfg.sv
module pestat_cfg (
    input  logic       clk,
    input  logic       por_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_val,
    output logic       mode_hold
);
    import pestat_pkg::*;

    logic legal;
    assign legal = (cfg_val == CFG_AUTO) || (cfg_val == CFG_HOLD);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            mode_hold <= 1'b0;
        else if (cfg_wr && legal)
            mode_hold <= (cfg_val == CFG_HOLD);
    end
endmodule

// File: rtl/pestat_fsm.sv
module pestat_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_start,
    input  logic                op_done,
    input  logic                op_fail,
    input  logic                id_exit,
    input  logic                mode_hold,
    output pestat_pkg::state_t  state,
    output logic                start_acc
);
    import pestat_pkg::*;

    state_t nxt;

    assign start_acc = (state == ST_READ) && op_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ:      if (op_start) nxt = ST_BUSY;
            ST_BUSY: begin
                if (op_fail)      nxt = ST_FAIL_WAIT;
                else if (op_done) nxt = mode_hold ? ST_DONE_WAIT : ST_READ;
            end
            ST_DONE_WAIT: if (id_exit) nxt = ST_READ;
            ST_FAIL_WAIT: if (id_exit) nxt = ST_READ;
        endcase
    end
endmodule

// File: rtl/pestat_track.sv
module pestat_track #(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc,
    input  logic              busy,
    input  logic              rd_stb,
    input  logic              op_is_erase,
    input  logic [DATA_W-1:0] op_data,
    output logic              tog_q,
    output logic              erase_q,
    output logic              bit_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q   <= 1'b0;
            erase_q <= 1'b0;
            bit_q   <= 1'b0;
        end else if (start_acc) begin
            tog_q   <= 1'b0;
            erase_q <= op_is_erase;
            bit_q   <= op_data[POLL_BIT];
        end else if (busy && rd_stb) begin
            tog_q   <= ~tog_q;
        end
    end
endmodule

// File: rtl/pestat_gen.sv
module pestat_gen #(
    parameter int DATA_W   = 16,
    parameter int POLL_BIT = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              dev_rst_n,
    input  logic              op_start,
    input  logic              op_is_erase,
    input  logic [DATA_W-1:0] op_data,
    input  logic              op_done,
    input  logic              op_fail,
    input  logic              rd_stb,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_val,
    input  logic              id_exit,
    output logic              show_status,
    output logic              dq7,
    output logic              dq6
);
    import pestat_pkg::*;

    logic   fsm_rst_n;
    logic   mode_hold;
    logic   start_acc;
    logic   tog_q, erase_q, bit_q;
    logic   busy_dq7;
    state_t state;

    assign fsm_rst_n = por_n & dev_rst_n;

    pestat_cfg u_cfg (
        .clk(clk), .por_n(por_n), .cfg_wr(cfg_wr),
        .cfg_val(cfg_val), .mode_hold(mode_hold)
    );

    pestat_fsm u_fsm (
        .clk(clk), .rst_n(fsm_rst_n), .op_start(op_start),
        .op_done(op_done), .op_fail(op_fail), .id_exit(id_exit),
        .mode_hold(mode_hold), .state(state), .start_acc(start_acc)
    );

    pestat_track #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT)) u_track (
        .clk(clk), .rst_n(fsm_rst_n), .start_acc(start_acc),
        .busy(state == ST_BUSY), .rd_stb(rd_stb),
        .op_is_erase(op_is_erase), .op_data(op_data),
        .tog_q(tog_q), .erase_q(erase_q), .bit_q(bit_q)
    );

    assign busy_dq7 = (!mode_hold && !erase_q) ? ~bit_q : 1'b0;

    always_comb begin
        show_status = 1'b1;
        dq7         = 1'b0;
        dq6         = 1'b0;
        unique case (state)
            ST_READ:      show_status = 1'b0;
            ST_BUSY:      begin dq7 = busy_dq7; dq6 = tog_q; end
            ST_DONE_WAIT: begin dq7 = 1'b1;     dq6 = tog_q; end
            ST_FAIL_WAIT: begin dq7 = busy_dq7; dq6 = tog_q; end
        endcase
    end
endmodule

// File: rtl/pestat_chk.sv
module pestat_chk (
    input logic               clk,
    input logic               por_n,
    input logic               dev_rst_n,
    input logic               cfg_wr,
    input logic               mode_hold,
    input pestat_pkg::state_t state,
    input logic               erase_q,
    input logic               rd_stb,
    input logic               op_done,
    input logic               op_fail,
    input logic               id_exit,
    input logic               show_status,
    input logic               dq7,
    input logic               dq6
);
    import pestat_pkg::*;

    // R2: the style only moves on a configuration write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!por_n)
        !cfg_wr |=> $stable(mode_hold));

    // R4: erase in style 00 polls low
    a_r4_erase_low: assert property (@(posedge clk) disable iff (!por_n || !dev_rst_n)
        (state == ST_BUSY && !mode_hold && erase_q) |-> (show_status && !dq7));

    // R5: automatic return in style 00
    a_r5_auto_return: assert property (@(posedge clk) disable iff (!por_n || !dev_rst_n)
        (state == ST_BUSY && !mode_hold && op_done && !op_fail) |=> !show_status);

    // R6: finished in style 01 reports high
    a_r6_done_high: assert property (@(posedge clk) disable iff (!por_n || !dev_rst_n)
        (state == ST_DONE_WAIT) |-> (dq7 && show_status));

    // R7: failure holds status until exit
    a_r7_fail_hold: assert property (@(posedge clk) disable iff (!por_n || !dev_rst_n)
        (state == ST_FAIL_WAIT && !id_exit) |=> show_status);

    // R8: a read while busy flips the toggle bit
    a_r8_toggle: assert property (@(posedge clk) disable iff (!por_n || !dev_rst_n)
        (state == ST_BUSY && rd_stb && !op_done && !op_fail) |=> (dq6 != $past(dq6)));
endmodule

bind pestat_gen pestat_chk u_chk (
    .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n), .cfg_wr(cfg_wr),
    .mode_hold(mode_hold), .state(state), .erase_q(erase_q),
    .rd_stb(rd_stb), .op_done(op_done), .op_fail(op_fail),
    .id_exit(id_exit), .show_status(show_status), .dq7(dq7), .dq6(dq6)
);

// File: tb/tb_pestat_gen.sv
`timescale 1ns/1ps
module tb_pestat_gen;
    localparam int DATA_W   = 16;
    localparam int POLL_BIT = 7;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic por_n = 1'b0, dev_rst_n = 1'b1;
    logic op_start = 0, op_is_erase = 0, op_done = 0, op_fail = 0;
    logic rd_stb = 0, cfg_wr = 0, id_exit = 0;
    logic [1:0] cfg_val = 2'b00;
    logic [DATA_W-1:0] op_data = '0;
    logic show_status, dq7, dq6;

    pestat_gen #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT)) dut (.*);

    int checks = 0, errors = 0;
    // model: 0 read, 1 busy, 2 done wait, 3 fail wait
    int  m_st = 0;
    bit  m_hold = 0, m_tog = 0, m_er = 0, m_bit = 0;

    function automatic bit busy_val(bit hold, bit er, bit b);
        return (!hold && !er) ? ~b : 1'b0;
    endfunction
    function automatic bit exp_st(int st);
        return st != 0;
    endfunction
    function automatic bit exp_d7(int st, bit hold, bit er, bit b);
        if (st == 0) return 0;
        if (st == 2) return 1;
        return busy_val(hold, er, b);
    endfunction
    function automatic bit exp_d6(int st, bit t);
        return (st == 0) ? 1'b0 : t;
    endfunction

    task automatic chk(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int nst;
        if (!por_n) begin
            m_st = 0; m_hold = 0; m_tog = 0; m_er = 0; m_bit = 0;
            return;
        end
        if (!dev_rst_n) begin
            m_st = 0; m_tog = 0; m_er = 0; m_bit = 0;
        end else begin
            nst = m_st;
            case (m_st)
                0: if (op_start) begin
                       nst = 1; m_tog = 0; m_er = op_is_erase; m_bit = op_data[POLL_BIT];
                   end
                1: begin
                       if (rd_stb) m_tog = ~m_tog;
                       if (op_fail) nst = 3;
                       else if (op_done) nst = m_hold ? 2 : 0;
                   end
                default: if (id_exit) nst = 0;
            endcase
            m_st = nst;
        end
        if (cfg_wr && !cfg_val[1]) m_hold = cfg_val[0];
    endtask

    task automatic tick(string t_st, string t_d7, string t_d6);
        @(posedge clk);
        #1;
        model_edge();
        chk(t_st, show_status, exp_st(m_st));
        chk(t_d7, dq7, exp_d7(m_st, m_hold, m_er, m_bit));
        chk(t_d6, dq6, exp_d6(m_st, m_tog));
        @(negedge clk);
        op_start = 0; op_done = 0; op_fail = 0; rd_stb = 0;
        cfg_wr = 0; id_exit = 0;
    endtask

    task automatic setcfg(logic [1:0] v);
        cfg_wr = 1; cfg_val = v; tick("R2_status", "R2_dq7", "R2_dq6");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        #1;
        // R1: values held during power-on reset
        chk("R1_status", show_status, 1'b0);
        chk("R1_dq7", dq7, 1'b0);
        chk("R1_dq6", dq6, 1'b0);
        @(negedge clk); @(negedge clk);
        por_n = 1;
        tick("R1_status", "R1_dq7", "R1_dq6");

        // R4: program in style 00 with bit 7 = 1, then R8 toggling
        op_start = 1; op_data = 16'h0080; tick("R4_status", "R4_dq7", "R8_dq6");
        chk("R4_prog_inv", dq7, 1'b0);
        rd_stb = 1; tick("R8_status", "R4_dq7", "R8_dq6");
        chk("R8_first_flip", dq6, 1'b1);
        rd_stb = 1; tick("R8_status", "R4_dq7", "R8_dq6");
        // R9: exit and start while busy are ignored
        id_exit = 1; op_start = 1; tick("R9_status", "R9_dq7", "R9_dq6");
        chk("R9_still_busy", show_status, 1'b1);
        // R5: done returns to array reads
        op_done = 1; tick("R5_status", "R5_dq7", "R5_dq6");
        chk("R5_auto", show_status, 1'b0);

        // R2: illegal code ignored, style stays 00
        setcfg(2'b11);
        op_start = 1; op_is_erase = 1; tick("R4_status", "R4_dq7", "R4_dq6");
        op_done = 1; tick("R2_status", "R2_dq7", "R2_dq6");
        chk("R2_ignored", show_status, 1'b0);

        // R6: style 01
        setcfg(2'b01);
        op_start = 1; op_is_erase = 0; op_data = 16'h0000; tick("R6_status", "R6_dq7", "R6_dq6");
        chk("R6_busy_low", dq7, 1'b0);
        op_done = 1; tick("R6_status", "R6_dq7", "R6_dq6");
        chk("R6_done_high", dq7, 1'b1);
        tick("R6_status", "R6_dq7", "R6_dq6");
        chk("R6_hold", show_status, 1'b1);
        id_exit = 1; tick("R6_status", "R6_dq7", "R6_dq6");
        chk("R6_exit", show_status, 1'b0);

        // R3: device reset keeps style 01
        op_start = 1; tick("R3_status", "R3_dq7", "R3_dq6");
        dev_rst_n = 0; tick("R3_status", "R3_dq7", "R3_dq6");
        chk("R3_to_read", show_status, 1'b0);
        dev_rst_n = 1; tick("R3_status", "R3_dq7", "R3_dq6");
        op_start = 1; tick("R3_status", "R3_dq7", "R3_dq6");
        op_done = 1; tick("R3_status", "R3_dq7", "R3_dq6");
        chk("R3_cfg_kept", dq7, 1'b1);

        // R7: fail with done in same cycle, style 00
        id_exit = 1; setcfg(2'b00);
        op_start = 1; op_data = 16'h0000; tick("R7_status", "R7_dq7", "R7_dq6");
        op_fail = 1; op_done = 1; rd_stb = 1; tick("R7_status", "R7_dq7", "R7_dq6");
        rd_stb = 1; tick("R7_status", "R7_dq7", "R8_frozen");
        chk("R7_hold", show_status, 1'b1);
        chk("R7_dq7_kept", dq7, 1'b1);
        id_exit = 1; tick("R7_status", "R7_dq7", "R7_dq6");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            op_start    = ($urandom_range(0, 5) == 0);
            op_is_erase = $urandom_range(0, 1);
            op_data     = DATA_W'($urandom);
            op_done     = ($urandom_range(0, 7) == 0);
            op_fail     = ($urandom_range(0, 19) == 0);
            rd_stb      = $urandom_range(0, 1);
            id_exit     = ($urandom_range(0, 7) == 0);
            cfg_wr      = ($urandom_range(0, 14) == 0);
            cfg_val     = 2'($urandom);
            dev_rst_n   = ($urandom_range(0, 59) != 0);
            tick("R5_status", "R4_R6_dq7", "R8_dq6");
        end
        dev_rst_n = 1;

        // R1: power-on reset returns style to 00
        setcfg(2'b01);
        @(negedge clk); por_n = 0; tick("R1_status", "R1_dq7", "R1_dq6");
        por_n = 1; tick("R1_status", "R1_dq7", "R1_dq6");
        op_start = 1; tick("R1_status", "R1_dq7", "R1_dq6");
        op_done = 1; tick("R1_status", "R1_dq7", "R1_dq6");
        chk("R1_cfg_cleared", show_status, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule